// File: doc/BRIEF.md
# Multi-source interrupt status controller

This block gathers five hardware event lines of a data-acquisition register file into one interrupt request. Every event line has its own enable bit. A rising edge on an enabled line sets a sticky pending flag. One request line is asserted while any flag is both pending and enabled, provided the master enable is also set.

Software uses a 16-bit register bus to reach the block. It writes a control word that holds the per-source enables and the master enable. It reads a status word that returns the pending flags next to three live FIFO level indicators. A write of any data to the clear address removes every pending flag. The event producers and the bus bridge sit outside the block.

Top module: `irq_status_ctrl`

## Requirements
- R1: During and straight after reset, all pending flags are zero, all enables and the master enable are off, and `irq` is low.
- R2: A 0-to-1 transition on `evt[i]` while enable bit i is set makes status bit 8+i read as 1 from the next cycle on. Source mapping: bit 0 is FIFO half full, bit 1 external, bit 2 channel list ready, bit 3 counter A, bit 4 counter B.
- R3: A transition on `evt[i]` while control bit 8+i is 0 has no effect, and status bit 8+i stays 0.
- R4: Capture is edge based. An event line held high sets its flag only once, so after a clear the flag stays 0 until the line falls and rises again.
- R5: A write with any data to address 0x04 clears every pending flag on the next cycle.
- R6: If a captured edge arrives in the same cycle as a clear write, that source's flag ends up set.
- R7: `irq` is registered. It goes high one cycle after a pending flag and its enable are both set while the master enable is on.
- R8: While control bit 15 (master enable) is 0, `irq` is low one cycle later, whatever flags are pending.
- R9: A read of address 0x04 returns FIFO full on bit 4, half full on bit 3 and empty on bit 2. These bits follow their inputs directly. Bits 15:13, 7:5 and 1:0 read 0.
- R10: A write to address 0x00 loads the enables (bits 12:8) and the master enable (bit 15). Clearing an enable masks its pending flag from `irq`, but the flag still shows in status.
- R11: A read of any address other than 0x04 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 5 | Event lines, one per source |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Read data, combinational |
| fifo_full | input | 1 | FIFO full level |
| fifo_half | input | 1 | FIFO half-full level |
| fifo_empty | input | 1 | FIFO empty level |
| irq | output | 1 | Interrupt request |

## Verification
An event edge or a clear write affects the status word one cycle after the clock edge on which it is sampled. `irq` is one more register stage behind, so it follows pending flags and enables with a single cycle of delay. The FIFO level bits and the read-address decode are combinational and appear in the same cycle. The bench drives every input on the falling edge and advances its model on the rising edge. It samples one time unit later, so every comparison uses exactly the state that edge produced.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 6;
    localparam int NUM_SRC   = 5;
    localparam int SRC_LSB   = 8;
    localparam int GLB_BIT   = 15;
    localparam int FULL_BIT  = 4;
    localparam int HALF_BIT  = 3;
    localparam int EMPTY_BIT = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h00;
    localparam logic [ADDR_W-1:0] CLR_ADDR  = 6'h04;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h04;

    typedef struct packed {
        logic prev;
        logic pend;
    } src_state_t;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pend_o
);
    src_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d      = st_q;
        hit       = evt_i && !st_q.prev && en_i;
        st_d.prev = evt_i;
        if (clr_i) st_d.pend = 1'b0;
        if (hit)   st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R3
    cap_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> ($past(en_i) && $past(evt_i)));

    // R5
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !pend_o);

    // R6
    clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i && en_i && !st_q.prev) |=> pend_o);
endmodule

// File: rtl/irq_status_mux.sv
module irq_status_mux
    import irq_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int A_W   = ADDR_W,
    parameter int N_SRC = NUM_SRC,
    parameter int LSB   = SRC_LSB,
    parameter logic [A_W-1:0] S_ADDR = STAT_ADDR
) (
    input  logic [A_W-1:0]   rd_addr_i,
    input  logic [N_SRC-1:0] pend_i,
    input  logic             full_i,
    input  logic             half_i,
    input  logic             empty_i,
    output logic [D_W-1:0]   rd_data_o
);
    logic [D_W-1:0] word_d;

    always_comb begin
        word_d = '0;
        if (rd_addr_i == S_ADDR) begin
            word_d[LSB +: N_SRC] = pend_i;
            word_d[FULL_BIT]     = full_i;
            word_d[HALF_BIT]     = half_i;
            word_d[EMPTY_BIT]    = empty_i;
        end
    end

    assign rd_data_o = word_d;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int A_W   = ADDR_W,
    parameter int N_SRC = NUM_SRC,
    parameter int LSB   = SRC_LSB,
    parameter int GLB   = GLB_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             wr_en,
    input  logic [A_W-1:0]   wr_addr,
    input  logic [D_W-1:0]   wr_data,
    input  logic [A_W-1:0]   rd_addr,
    output logic [D_W-1:0]   rd_data,
    input  logic             fifo_full,
    input  logic             fifo_half,
    input  logic             fifo_empty,
    output logic             irq
);
    localparam int HI_GAP = GLB - (LSB + N_SRC);

    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic             glb;
        logic             irq;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [N_SRC-1:0] pend;
    logic             clr_wr;
    logic             unused_wr_bits;

    assign clr_wr         = wr_en && (wr_addr == CLR_ADDR);
    assign unused_wr_bits = ^{wr_data[LSB-1:0], wr_data[GLB-1 -: HI_GAP]};

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            irq_src_latch u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt_i  (evt[i]),
                .en_i   (st_q.en[i]),
                .clr_i  (clr_wr),
                .pend_o (pend[i])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.irq = (|(pend & st_q.en)) && st_q.glb;
        if (wr_en && (wr_addr == CTRL_ADDR)) begin
            st_d.en  = wr_data[LSB +: N_SRC];
            st_d.glb = wr_data[GLB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    irq_status_mux #(
        .D_W    (D_W),
        .A_W    (A_W),
        .N_SRC  (N_SRC),
        .LSB    (LSB),
        .S_ADDR (STAT_ADDR)
    ) u_mux (
        .rd_addr_i (rd_addr),
        .pend_i    (pend),
        .full_i    (fifo_full),
        .half_i    (fifo_half),
        .empty_i   (fifo_empty),
        .rd_data_o (rd_data)
    );

    assign irq = st_q.irq;

    // R8
    glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.glb |=> !irq);

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(st_q.glb) && $past(|pend)));

    // R11
    rd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != STAT_ADDR) |-> (rd_data == '0));
endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  evt;
    logic        wr_en;
    logic [5:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic        fifo_full, fifo_half, fifo_empty, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [4:0] m_en, m_pend, m_prev;
    logic       m_glb, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .fifo_full(fifo_full), .fifo_half(fifo_half),
        .fifo_empty(fifo_empty), .irq(irq)
    );

    function automatic logic [15:0] exp_status(input logic [5:0] a);
        logic [15:0] w = '0;
        if (a == 6'h04) begin
            w[12:8] = m_pend;
            w[4]    = fifo_full;
            w[3]    = fifo_half;
            w[2]    = fifo_empty;
        end
        return w;
    endfunction

    task automatic check(input string tag);
        logic [15:0] e;
        e = exp_status(rd_addr);
        n_chk++;
        if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, e);
        end
        n_chk++;
        if (irq !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq actual %b expected %b", tag, irq, m_irq);
        end
    endtask

    task automatic step(input logic [4:0] e, input logic we, input logic [5:0] wa,
                        input logic [15:0] wd, input logic [5:0] ra,
                        input logic [2:0] ff, input string tag);
        logic       clr, cw, n_glb, n_irq;
        logic [4:0] n_pend, n_en;
        @(negedge clk);
        evt = e; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        {fifo_full, fifo_half, fifo_empty} = ff;
        clr    = we && (wa == 6'h04);
        cw     = we && (wa == 6'h00);
        n_pend = (clr ? 5'b0 : m_pend) | (e & ~m_prev & m_en);
        n_irq  = (|(m_pend & m_en)) && m_glb;
        n_en   = cw ? wd[12:8] : m_en;
        n_glb  = cw ? wd[15] : m_glb;
        @(posedge clk);
        #1;
        m_pend = n_pend; m_irq = n_irq; m_en = n_en; m_glb = n_glb; m_prev = e;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1357_9bdf);
        m_en = '0; m_pend = '0; m_prev = '0; m_glb = 1'b0; m_irq = 1'b0;
        rst_n = 1'b0; evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = 6'h04; fifo_full = 1'b1; fifo_half = 1'b0; fifo_empty = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1");
        @(negedge clk) rst_n = 1'b1;
        step(5'b0, 0, 6'h00, 16'h0, 6'h04, 3'b101, "R1");
        // R11: other addresses read zero
        step(5'b0, 0, 6'h00, 16'h0, 6'h00, 3'b111, "R11");
        step(5'b0, 0, 6'h00, 16'h0, 6'h10, 3'b111, "R11");
        // R10: enable all plus master
        step(5'b0, 1, 6'h00, 16'h9F00, 6'h04, 3'b000, "R10");
        // R2 then R7
        step(5'b00001, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R2");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R7");
        step(5'b10000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R2");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R7");
        // R5: clear with arbitrary data
        step(5'b00000, 1, 6'h04, 16'hBEEF, 6'h04, 3'b000, "R5");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R5");
        // R3: source 0 disabled
        step(5'b00000, 1, 6'h00, 16'h9E00, 6'h04, 3'b000, "R3");
        step(5'b00001, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R3");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R3");
        // R4: held level, clear, stays clear
        step(5'b00000, 1, 6'h00, 16'h9F00, 6'h04, 3'b000, "R4");
        step(5'b00100, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R4");
        step(5'b00100, 1, 6'h04, 16'h0000, 6'h04, 3'b000, "R4");
        for (int k = 0; k < 4; k++) step(5'b00100, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R4");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R4");
        // R6: edge and clear together
        step(5'b00010, 1, 6'h04, 16'h1234, 6'h04, 3'b000, "R6");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R6");
        // R8: master off keeps irq low
        step(5'b00000, 1, 6'h00, 16'h1F00, 6'h04, 3'b000, "R8");
        step(5'b01000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R8");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R8");
        // R10: enables off, pending stays visible, irq masked
        step(5'b00000, 1, 6'h00, 16'h8000, 6'h04, 3'b000, "R10");
        step(5'b00000, 0, 6'h00, 16'h0, 6'h04, 3'b000, "R10");
        // R9: FIFO level patterns
        for (int f = 0; f < 8; f++) step(5'b0, 0, 6'h00, 16'h0, 6'h04, f[2:0], "R9");
        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [4:0]  e;
            logic        we;
            logic [5:0]  wa, ra;
            logic [15:0] wd;
            e  = 5'($urandom) & 5'($urandom);
            we = ($urandom % 6) == 0;
            case ($urandom % 3)
                0: wa = 6'h00;
                1: wa = 6'h04;
                default: wa = 6'($urandom);
            endcase
            wd = 16'($urandom);
            ra = (($urandom % 5) == 0) ? 6'($urandom) : 6'h04;
            step(e, we, wa, wd, ra, 3'($urandom), "R2");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule